// File: doc/BRIEF.md
# Precise Exception Controller for a Five-Stage Pipeline

This block turns two fault reports from a five-stage in-order pipeline into a precise trap. Decode reports an instruction whose opcode is not defined. Execute reports a signed overflow on an add. Each report comes with the program counter of the instruction that raised it. When a report is accepted, the block squashes the faulting instruction and every younger one. It uses the same per-stage squash lines that a mispredicted branch uses, so the squashed stages become bubbles and the faulting instruction never writes its destination register. Instructions older than the fault, which sit in the memory and write-back stages, are left alone and complete.

In the same cycle the block sends fetch to a fixed handler address. On the clock edge that ends that cycle it captures two values: the faulting program counter in an exception-PC register, and a reason code in a cause register. Both hold until the next accepted fault or reset. Fault checks and redirects are combinational, so the squash acts on the instructions that are in the pipeline at that moment. For one cycle after an accepted fault, new reports are ignored, because the stages that could raise them hold only bubbles. As a result, every squash and redirect lasts exactly one cycle.

Top module: `exc_precise_ctrl`

## Requirements
- R1: While reset is held low at a clock edge, and in the cycle after, `epc_o` and `cause_o` read 0. With no report present, `stage_flush_o` is 0 and `redirect_valid_o` is 0.
- R2: In a cycle where `ex_overflow_i` is accepted, `stage_flush_o` reads 5'b00111 in that same cycle. Bit 0 squashes fetch, bit 1 squashes decode and bit 2 squashes execute. Bits 3 (memory) and 4 (write-back) stay 0.
- R3: In a cycle where `dec_illegal_i` is accepted and no overflow is reported, `stage_flush_o` reads 5'b00011. The instruction in execute continues.
- R4: `redirect_valid_o` is 1 in exactly the cycles in which a report is accepted. In those cycles `redirect_pc_o` is the handler vector 32'h8000_0180. In all other cycles `redirect_pc_o` is 0.
- R5: After the clock edge that ends a cycle with an accepted report, `epc_o` holds the program counter of the faulting instruction.
- R6: `cause_o` carries the reason code in bits [6:2]: 12 for overflow (word 32'h0000_0030) and 10 for an undefined opcode (word 32'h0000_0028). All other bits read 0.
- R7: When both reports arrive in the same cycle, the execute report wins: `stage_flush_o` is 5'b00111, `epc_o` takes `ex_pc_i`, and the cause code is 12.
- R8: In the cycle right after an accepted report, any new report is ignored. In that cycle there is no squash and no redirect, and `epc_o` and `cause_o` keep their values. A report held for two cycles therefore gives a one-cycle pulse. A report in the cycle after that is accepted again.
- R9: In a cycle with no accepted report, `epc_o` and `cause_o` keep their values across the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| dec_illegal_i | input | 1 | Decode holds an instruction with an undefined opcode |
| dec_pc_i | input | 32 | Program counter of the instruction in decode |
| ex_overflow_i | input | 1 | Execute produced a signed add overflow |
| ex_pc_i | input | 32 | Program counter of the instruction in execute |
| stage_flush_o | output | 5 | Per-stage squash: bit 0 fetch, 1 decode, 2 execute, 3 memory, 4 write-back |
| redirect_valid_o | output | 1 | Fetch must load `redirect_pc_o` this cycle |
| redirect_pc_o | output | 32 | Handler vector while redirecting, otherwise 0 |
| epc_o | output | 32 | Program counter of the last accepted faulting instruction |
| cause_o | output | 32 | Reason code of the last accepted fault in bits [6:2] |

## Verification
A wrong priority between the two sources shows up in the same cycle as an extra or missing squash bit. It also shows up one edge later as the wrong program counter in `epc_o`, since the pipeline keeps the decode-stage PC and the execute-stage PC apart. A stuck or missing blanking flag shows up on the very next cycle, as a second redirect pulse or as a fault that is dropped when it should be accepted. Corrupted storage in the exception-PC or cause register appears at those outputs one edge after the disturbing cycle, and it then stays visible until the next fault, so quiet cycles after each trap are the ones that expose it.

// File: rtl/exc_pkg.sv
// Package exc_pkg
// Shared constants and types for the precise exception controller.
// Assumes a five-stage in-order pipeline with stage index 0 at fetch.
package exc_pkg;

    // Stage positions inside the per-stage squash vector
    localparam int STG_FETCH  = 0;
    localparam int STG_DECODE = 1;
    localparam int STG_EXEC   = 2;
    localparam int STG_MEM    = 3;
    localparam int STG_WBACK  = 4;

    // Reason codes placed in cause bits [6:2]
    localparam logic [4:0] CODE_OVERFLOW = 5'd12;
    localparam logic [4:0] CODE_BAD_OP   = 5'd10;

    // Which stage raised the accepted fault
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_DEC  = 2'd1,
        SRC_EXE  = 2'd2
    } exc_src_e;

endpackage

// File: rtl/exc_arbiter.sv
// Module exc_arbiter
// Chooses which fault report is accepted this cycle. The execute report is
// older in program order, so it wins over the decode report. A set mask
// (the blanking cycle after a trap) rejects both.
// Assumes the reports are valid only for the cycle they are raised in.
module exc_arbiter
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            dec_illegal,
    input  logic [XLEN-1:0] dec_pc,
    input  logic            ex_overflow,
    input  logic [XLEN-1:0] ex_pc,
    input  logic            mask,
    output logic            take,
    output exc_src_e        src,
    output logic [XLEN-1:0] fault_pc,
    output logic [4:0]      code
);

    // Priority pick: execute over decode, nothing while masked
    always_comb begin
        take     = 1'b0;
        src      = SRC_NONE;
        fault_pc = '0;
        code     = '0;
        if (!mask) begin
            if (ex_overflow) begin
                take     = 1'b1;
                src      = SRC_EXE;
                fault_pc = ex_pc;
                code     = CODE_OVERFLOW;
            end else if (dec_illegal) begin
                take     = 1'b1;
                src      = SRC_DEC;
                fault_pc = dec_pc;
                code     = CODE_BAD_OP;
            end
        end
    end

endmodule

// File: rtl/exc_flush_gen.sv
// Module exc_flush_gen
// Builds the per-stage squash vector. Every stage from fetch up to and
// including the stage that raised the fault is squashed. Older stages
// keep running so their instructions complete.
// Assumes NSTAGE >= 3 and that stage index grows with instruction age.
module exc_flush_gen
    import exc_pkg::*;
#(
    parameter int NSTAGE = 5
) (
    input  logic              take,
    input  exc_src_e          src,
    output logic [NSTAGE-1:0] flush
);

    int depth;

    // Map the fault source to the oldest stage that must be squashed
    always_comb begin
        case (src)
            SRC_EXE: depth = STG_EXEC;
            SRC_DEC: depth = STG_DECODE;
            default: depth = -1;
        endcase
    end

    // One squash line per stage
    for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
        localparam int IDX = s;
        assign flush[s] = take && (IDX <= depth);
    end

endmodule

// File: rtl/exc_state_regs.sv
// Module exc_state_regs
// Holds the exception-PC and cause registers and the one-cycle blanking
// flag. Both registers load only on the edge that ends an accepted fault.
// Assumes a synchronous active-low reset.
module exc_state_regs #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  logic [XLEN-1:0] fault_pc,
    input  logic [4:0]      code,
    output logic [XLEN-1:0] epc,
    output logic [XLEN-1:0] cause,
    output logic            blank
);

    localparam int PAD = XLEN - 7;

    // Capture the fault PC and code on an accepted fault
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc   <= '0;
            cause <= '0;
        end else if (take) begin
            epc   <= fault_pc;
            cause <= {{PAD{1'b0}}, code, 2'b00};
        end
    end

    // Reject reports for the single cycle after a trap
    always_ff @(posedge clk) begin
        if (!rst_n) blank <= 1'b0;
        else        blank <= take;
    end

endmodule

// File: rtl/exc_precise_ctrl.sv
// Module exc_precise_ctrl
// Top of the precise exception controller. It accepts at most one fault per
// cycle, squashes the faulting stage and every younger one, redirects fetch
// to the handler vector, and records the fault PC and reason.
// Assumes the pipeline applies stage_flush_o to its stage registers in the
// same cycle, exactly as it does for a branch squash.
module exc_precise_ctrl
    import exc_pkg::*;
#(
    parameter int              XLEN   = 32,
    parameter int              NSTAGE = 5,
    parameter logic [XLEN-1:0] VECTOR = 32'h8000_0180
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_illegal_i,
    input  logic [XLEN-1:0]   dec_pc_i,
    input  logic              ex_overflow_i,
    input  logic [XLEN-1:0]   ex_pc_i,
    output logic [NSTAGE-1:0] stage_flush_o,
    output logic              redirect_valid_o,
    output logic [XLEN-1:0]   redirect_pc_o,
    output logic [XLEN-1:0]   epc_o,
    output logic [XLEN-1:0]   cause_o
);

    logic            take;
    logic            blank;
    exc_src_e        src;
    logic [XLEN-1:0] fault_pc;
    logic [4:0]      code;

    exc_arbiter #(.XLEN(XLEN)) u_arb (
        .dec_illegal (dec_illegal_i),
        .dec_pc      (dec_pc_i),
        .ex_overflow (ex_overflow_i),
        .ex_pc       (ex_pc_i),
        .mask        (blank),
        .take        (take),
        .src         (src),
        .fault_pc    (fault_pc),
        .code        (code)
    );

    exc_flush_gen #(.NSTAGE(NSTAGE)) u_flush (
        .take  (take),
        .src   (src),
        .flush (stage_flush_o)
    );

    exc_state_regs #(.XLEN(XLEN)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .fault_pc (fault_pc),
        .code     (code),
        .epc      (epc_o),
        .cause    (cause_o),
        .blank    (blank)
    );

    // Fetch redirect to the fixed handler vector
    assign redirect_valid_o = take;
    assign redirect_pc_o    = take ? VECTOR : '0;

endmodule

// File: rtl/exc_precise_ctrl_chk.sv
// Module exc_precise_ctrl_chk
// Port-level checker for exc_precise_ctrl, bound to every instance.
// Assumes the default five stages and 32-bit program counters.
module exc_precise_ctrl_chk #(
    parameter int              XLEN   = 32,
    parameter int              NSTAGE = 5,
    parameter logic [XLEN-1:0] VECTOR = 32'h8000_0180
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dec_illegal_i,
    input logic [XLEN-1:0]   dec_pc_i,
    input logic              ex_overflow_i,
    input logic [XLEN-1:0]   ex_pc_i,
    input logic [NSTAGE-1:0] stage_flush_o,
    input logic              redirect_valid_o,
    input logic [XLEN-1:0]   redirect_pc_o,
    input logic [XLEN-1:0]   epc_o,
    input logic [XLEN-1:0]   cause_o
);

    logic            prev_take;
    logic [XLEN-1:0] exp_pc;

    // Track whether the previous cycle redirected
    always_ff @(posedge clk) begin
        if (!rst_n) prev_take <= 1'b0;
        else        prev_take <= redirect_valid_o;
    end

    // Fault PC the winning source should leave in the exception-PC register
    assign exp_pc = ex_overflow_i ? ex_pc_i : dec_pc_i;

    AST_OVF_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_overflow_i && !prev_take) |-> (stage_flush_o[2:0] == 3'b111 && stage_flush_o[NSTAGE-1:3] == '0)); // R2
    AST_BADOP_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_illegal_i && !ex_overflow_i && !prev_take) |-> (stage_flush_o[2:0] == 3'b011 && stage_flush_o[NSTAGE-1:3] == '0)); // R3
    AST_REDIRECT_PC: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid_o |-> (redirect_pc_o == VECTOR)); // R4
    AST_EPC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid_o |=> (epc_o == $past(exp_pc))); // R5
    AST_CAUSE_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_o[1:0] == 2'b00 && cause_o[XLEN-1:7] == '0)); // R6
    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid_o |=> !redirect_valid_o); // R8
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect_valid_o |=> ($stable(epc_o) && $stable(cause_o))); // R9

endmodule

bind exc_precise_ctrl exc_precise_ctrl_chk #(
    .XLEN(XLEN), .NSTAGE(NSTAGE), .VECTOR(VECTOR)
) u_chk (.*);

// File: tb/exc_precise_ctrl_tb.sv
// Directed bench for exc_precise_ctrl: one task per scenario.
module exc_precise_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] VEC = 32'h8000_0180;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        dec_illegal_i;
    logic [31:0] dec_pc_i;
    logic        ex_overflow_i;
    logic [31:0] ex_pc_i;
    logic [4:0]  stage_flush_o;
    logic        redirect_valid_o;
    logic [31:0] redirect_pc_o;
    logic [31:0] epc_o;
    logic [31:0] cause_o;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_precise_ctrl u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .dec_illegal_i    (dec_illegal_i),
        .dec_pc_i         (dec_pc_i),
        .ex_overflow_i    (ex_overflow_i),
        .ex_pc_i          (ex_pc_i),
        .stage_flush_o    (stage_flush_o),
        .redirect_valid_o (redirect_valid_o),
        .redirect_pc_o    (redirect_pc_o),
        .epc_o            (epc_o),
        .cause_o          (cause_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive inputs after the falling edge, then let the logic settle
    task automatic drive(input logic ill, input logic [31:0] dpc, input logic ovf, input logic [31:0] epc);
        @(negedge clk);
        dec_illegal_i = ill;
        dec_pc_i      = dpc;
        ex_overflow_i = ovf;
        ex_pc_i       = epc;
        #1;
    endtask

    task automatic idle();
        drive(1'b0, 32'h0, 1'b0, 32'h0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        drive(1'b0, 32'h0, 1'b0, 32'h0);
        drive(1'b0, 32'h0, 1'b0, 32'h0);
        check("R1 epc in reset", epc_o, 32'h0);
        check("R1 cause in reset", cause_o, 32'h0);
        check("R1 flush in reset", {27'h0, stage_flush_o}, 32'h0);
        check("R1 redirect in reset", {31'h0, redirect_valid_o}, 32'h0);
        rst_n = 1'b1;
        idle();
        check("R1 epc after reset", epc_o, 32'h0);
    endtask

    task automatic t_overflow();
        drive(1'b0, 32'h0000_1000, 1'b1, 32'h0000_004C);
        check("R2 overflow flush", {27'h0, stage_flush_o}, 32'h07);
        check("R4 redirect valid", {31'h0, redirect_valid_o}, 32'h1);
        check("R4 redirect pc", redirect_pc_o, VEC);
        idle();
        check("R5 epc overflow", epc_o, 32'h0000_004C);
        check("R6 cause overflow", cause_o, 32'h0000_0030);
        check("R4 redirect pc idle", redirect_pc_o, 32'h0);
    endtask

    task automatic t_badop();
        drive(1'b1, 32'h0000_2040, 1'b0, 32'h0000_203C);
        check("R3 bad opcode flush", {27'h0, stage_flush_o}, 32'h03);
        check("R4 redirect bad opcode", redirect_pc_o, VEC);
        idle();
        check("R5 epc bad opcode", epc_o, 32'h0000_2040);
        check("R6 cause bad opcode", cause_o, 32'h0000_0028);
    endtask

    task automatic t_both();
        drive(1'b1, 32'h0000_3004, 1'b1, 32'h0000_3000);
        check("R7 both flush", {27'h0, stage_flush_o}, 32'h07);
        idle();
        check("R7 both epc", epc_o, 32'h0000_3000);
        check("R7 both cause", cause_o, 32'h0000_0030);
    endtask

    task automatic t_blank();
        drive(1'b1, 32'h0000_5000, 1'b0, 32'h0);
        check("R8 first cycle accepted", {31'h0, redirect_valid_o}, 32'h1);
        drive(1'b0, 32'h0, 1'b1, 32'h0000_5555);
        check("R8 blank no redirect", {31'h0, redirect_valid_o}, 32'h0);
        check("R8 blank no flush", {27'h0, stage_flush_o}, 32'h0);
        check("R8 epc from first", epc_o, 32'h0000_5000);
        drive(1'b0, 32'h0, 1'b1, 32'h0000_6000);
        check("R8 blank cleared", {31'h0, redirect_valid_o}, 32'h1);
        check("R8 epc unchanged by blank report", epc_o, 32'h0000_5000);
        check("R8 cause unchanged by blank report", cause_o, 32'h0000_0028);
        idle();
        check("R8 epc after reaccept", epc_o, 32'h0000_6000);
    endtask

    task automatic t_quiet();
        idle();
        idle();
        idle();
        check("R9 epc held", epc_o, 32'h0000_6000);
        check("R9 cause held", cause_o, 32'h0000_0030);
        check("R9 no flush", {27'h0, stage_flush_o}, 32'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        dec_illegal_i = 1'b0;
        dec_pc_i      = '0;
        ex_overflow_i = 1'b0;
        ex_pc_i       = '0;
        rst_n         = 1'b0;
        t_reset();
        t_overflow();
        t_badop();
        t_both();
        t_blank();
        t_quiet();
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule